// File: doc/BRIEF.md
# Two-Button Passcode Lock Controller

This block is the control core of a simple digital lock. The user keys in a fixed binary code one digit at a time. One push button enters a 1, a second enters a 0, and a third clears the lock back to its starting point. Once the code length has been entered, two registered outputs report the result. `pass_o` goes high when every digit matched and `fail_o` goes high when at least one did not. The result stays in place until the clear button is pressed.

The raw buttons are asynchronous to the system clock. Each one goes through a chain of synchronizing flops. The two digit buttons then go through a rising-edge detector, which turns one press into a single one-cycle pulse, however long the button is held. Every state update is made on the system clock.

A wrong digit does not end the entry early. The controller keeps counting digits and marks the attempt as bad, so the result only appears after the full code length. The code value and its length are parameters; the default is four digits.

Top module: `two_button_lock`

## Requirements
- R1: With the default code, the digit sequence 1, 0, 1, 0 (first digit compared against the most significant bit of the code parameter) drives `pass_o` high with `fail_o` low.
- R2: A press of `btn_one_i` enters a 1 and a press of `btn_zero_i` enters a 0; all buttons are active-high (1 = pressed).
- R3: Both `pass_o` and `fail_o` stay low until exactly the code length of digits (four by default) has been entered.
- R4: A mismatch at any position, including the first and the last, still consumes the remaining digits, and `fail_o` goes high only after the final digit.
- R5: Once `pass_o` or `fail_o` is high, it stays high until the clear button or `rst` is applied.
- R6: Holding `btn_clear_i` returns the controller to its initial state: both outputs go low, and a following entry starts again from the first digit.
- R7: One press counts as exactly one digit, however many clock cycles the button is held.
- R8: If the two digit buttons produce their press pulses in the same cycle, that entry is ignored and the digit position does not advance.
- R9: Digit presses made while a result is shown have no effect on either output.
- R10: While `rst` is high at a clock edge the controller returns to its initial state, and both outputs are low after reset.
- R11: `pass_o` and `fail_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_one_i | input | 1 | Raw button that enters a 1 (asynchronous, active-high) |
| btn_zero_i | input | 1 | Raw button that enters a 0 (asynchronous, active-high) |
| btn_clear_i | input | 1 | Raw clear button (asynchronous, active-high) |
| pass_o | output | 1 | Registered: correct code entered |
| fail_o | output | 1 | Registered: wrong code entered |

## Verification
The hardest case to reach from the ports is two press pulses landing in the same clock cycle. The edge detectors normally keep presses apart, so this only happens when both raw buttons rise ahead of the same clock edge. The bench raises both raw inputs at the same falling edge so they pass through the synchronizers in lockstep. It then completes a normal code entry and checks that the result needed exactly the code length of further digits, which proves the double press did not use up a position. A long press held for many cycles is treated the same way: it is followed by the rest of the code, so any extra digit counted would show up as an early or wrong result.

// File: rtl/lock_pkg.sv
package lock_pkg;

  // Controller phase; encoding 2'b11 is unused and recovers to LK_ENTRY.
  typedef enum logic [1:0] {
    LK_ENTRY = 2'b00,
    LK_OPEN  = 2'b01,
    LK_DENY  = 2'b10
  } lock_phase_e;

  // Index of the code bit that digit position pos is compared against.
  function automatic int unsigned code_bit_index(input int unsigned code_len,
                                                 input int unsigned pos);
    return code_len - 1 - pos;
  endfunction

endpackage

// File: rtl/lock_btn_sync.sv
module lock_btn_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] level_o
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q <= '0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], raw_i[b]};
        end
      end

      assign level_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/lock_edge_det.sv
module lock_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] pulse_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
    end else begin
      prev_q <= level_i;
    end
  end

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_rise
      assign pulse_o[b] = level_i[b] & ~prev_q[b];
    end
  endgenerate

endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import lock_pkg::*;
#(
  parameter int          CODE_LEN = 4,
  parameter logic [CODE_LEN-1:0] CODE = 4'b1010,
  localparam int         CNT_W    = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             one_p_i,
  input  logic             zero_p_i,
  output lock_phase_e      phase_o,
  output logic [CNT_W-1:0] pos_o
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CODE_LEN - 1);

  lock_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             bad_q, bad_d;

  logic digit_valid;
  logic digit_val;
  logic digit_match;
  logic bad_next;

  assign digit_valid = one_p_i ^ zero_p_i;
  assign digit_val   = one_p_i;
  assign digit_match = (digit_val == CODE[code_bit_index(CODE_LEN, int'(pos_q))]);
  assign bad_next    = bad_q | ~digit_match;

  always_comb begin
    phase_d = phase_q;
    pos_d   = pos_q;
    bad_d   = bad_q;
    if (clear_i) begin
      phase_d = LK_ENTRY;
      pos_d   = '0;
      bad_d   = 1'b0;
    end else begin
      case (phase_q)
        LK_ENTRY: begin
          if (digit_valid) begin
            if (pos_q == LAST_POS) begin
              phase_d = bad_next ? LK_DENY : LK_OPEN;
              pos_d   = '0;
              bad_d   = 1'b0;
            end else begin
              pos_d = pos_q + 1'b1;
              bad_d = bad_next;
            end
          end
        end
        LK_OPEN, LK_DENY: begin
          phase_d = phase_q;
        end
        default: begin
          phase_d = LK_ENTRY;
          pos_d   = '0;
          bad_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= LK_ENTRY;
      pos_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pos_q   <= pos_d;
      bad_q   <= bad_d;
    end
  end

  assign phase_o = phase_q;
  assign pos_o   = pos_q;

endmodule

// File: rtl/lock_result_reg.sv
module lock_result_reg
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_phase_e phase_i,
  output logic        pass_o,
  output logic        fail_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      pass_o <= (phase_i == LK_OPEN);
      fail_o <= (phase_i == LK_DENY);
    end
  end

endmodule

// File: rtl/two_button_lock.sv
module two_button_lock
  import lock_pkg::*;
#(
  parameter int                  CODE_LEN    = 4,
  parameter logic [CODE_LEN-1:0] CODE        = 4'b1010,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_one_i,
  input  logic btn_zero_i,
  input  logic btn_clear_i,
  output logic pass_o,
  output logic fail_o
);

  localparam int CNT_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;

  logic [2:0]       btn_lvl;
  logic [1:0]       digit_pulse;
  logic             clr_lvl;
  logic             one_p;
  logic             zero_p;
  lock_phase_e      phase;
  logic [CNT_W-1:0] pos;

  lock_btn_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .raw_i   ({btn_clear_i, btn_zero_i, btn_one_i}),
    .level_o (btn_lvl)
  );

  lock_edge_det #(
    .WIDTH (2)
  ) u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (btn_lvl[1:0]),
    .pulse_o (digit_pulse)
  );

  assign one_p   = digit_pulse[0];
  assign zero_p  = digit_pulse[1];
  assign clr_lvl = btn_lvl[2];

  lock_seq_fsm #(
    .CODE_LEN (CODE_LEN),
    .CODE     (CODE)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (clr_lvl),
    .one_p_i  (one_p),
    .zero_p_i (zero_p),
    .phase_o  (phase),
    .pos_o    (pos)
  );

  lock_result_reg u_result (
    .clk     (clk),
    .rst     (rst),
    .phase_i (phase),
    .pass_o  (pass_o),
    .fail_o  (fail_o)
  );

endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_lvl,
  input logic             one_p,
  input logic             zero_p,
  input logic [1:0]       phase,
  input logic [CNT_W-1:0] pos,
  input logic             pass_o,
  input logic             fail_o
);

  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o)); // R11

  AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pass_o && !clr_lvl) |=> pass_o); // R5

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !clr_lvl) |=> fail_o); // R5

  AST_RESULT_FOLLOWS_DIGIT: assert property (@(posedge clk) disable iff (rst)
    ($rose(pass_o) || $rose(fail_o)) |-> $past(one_p ^ zero_p, 2)); // R3

  AST_DUAL_PRESS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (one_p && zero_p && !clr_lvl) |=> ($stable(pos) && $stable(phase))); // R8

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    clr_lvl |=> (pos == '0 && phase == 2'b00)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (one_p || zero_p) |=> !(one_p || zero_p)); // R7

  AST_TERMINAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'b00 && !clr_lvl) |=> $stable(phase)); // R9

endmodule

bind two_button_lock lock_checker #(.CNT_W(CNT_W)) u_lock_checker (
  .clk     (clk),
  .rst     (rst),
  .clr_lvl (clr_lvl),
  .one_p   (one_p),
  .zero_p  (zero_p),
  .phase   (phase),
  .pos     (pos),
  .pass_o  (pass_o),
  .fail_o  (fail_o)
);

// File: tb/test_two_button_lock.sv
`timescale 1ns/1ps
module test_two_button_lock;

  logic clk = 1'b0;
  logic rst;
  logic btn_one, btn_zero, btn_clear;
  logic pass_o, fail_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  two_button_lock i_two_button_lock (
    .clk         (clk),
    .rst         (rst),
    .btn_one_i   (btn_one),
    .btn_zero_i  (btn_zero),
    .btn_clear_i (btn_clear),
    .pass_o      (pass_o),
    .fail_o      (fail_o)
  );

  task automatic expect_out(input logic exp_pass, input logic exp_fail,
                            input string req);
    n_tests++;
    if (pass_o !== exp_pass || fail_o !== exp_fail) begin
      n_fail++;
      $display("FAIL %s: {pass,fail} actual %b%b expected %b%b",
               req, pass_o, fail_o, exp_pass, exp_fail);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One press of a digit button (1 -> one button, 0 -> zero button).
  task automatic press(input logic digit, input int hold);
    @(negedge clk);
    if (digit) btn_one = 1'b1; else btn_zero = 1'b1;
    idle(hold);
    btn_one  = 1'b0;
    btn_zero = 1'b0;
    idle(5);
  endtask

  task automatic do_clear();
    @(negedge clk);
    btn_clear = 1'b1;
    idle(3);
    btn_clear = 1'b0;
    idle(5);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    btn_one = 1'b0; btn_zero = 1'b0; btn_clear = 1'b0;
    idle(5);
    expect_out(1'b0, 1'b0, "R10 outputs during reset");
    rst = 1'b0;
    idle(3);
    expect_out(1'b0, 1'b0, "R10 outputs after reset");
  endtask

  task automatic t_correct_code();
    press(1'b1, 2); expect_out(1'b0, 1'b0, "R3 after digit 1");
    press(1'b0, 2); expect_out(1'b0, 1'b0, "R3 after digit 2");
    press(1'b1, 2); expect_out(1'b0, 1'b0, "R3 after digit 3");
    press(1'b0, 2); expect_out(1'b1, 1'b0, "R1 R2 correct code 1010");
    idle(40);
    expect_out(1'b1, 1'b0, "R5 pass sticky");
    press(1'b0, 2);
    press(1'b1, 2);
    expect_out(1'b1, 1'b0, "R9 presses ignored after pass");
    do_clear();
    expect_out(1'b0, 1'b0, "R6 clear after pass");
  endtask

  task automatic t_wrong_first();
    press(1'b0, 2);
    expect_out(1'b0, 1'b0, "R4 no early fail on first digit");
    press(1'b0, 2);
    press(1'b1, 2);
    expect_out(1'b0, 1'b0, "R4 three digits, wrong path");
    press(1'b0, 2);
    expect_out(1'b0, 1'b1, "R4 fail after fourth digit");
    idle(30);
    expect_out(1'b0, 1'b1, "R5 fail sticky");
    press(1'b1, 2);
    expect_out(1'b0, 1'b1, "R9 press ignored after fail");
    do_clear();
    expect_out(1'b0, 1'b0, "R6 clear after fail");
  endtask

  task automatic t_wrong_last();
    press(1'b1, 2); press(1'b0, 2); press(1'b1, 2);
    press(1'b1, 2);
    expect_out(1'b0, 1'b1, "R4 mismatch on last digit");
    do_clear();
  endtask

  task automatic t_long_hold();
    press(1'b1, 30);
    press(1'b0, 25);
    press(1'b1, 40);
    expect_out(1'b0, 1'b0, "R7 long holds count once each");
    press(1'b0, 1);
    expect_out(1'b1, 1'b0, "R7 long holds then pass");
    do_clear();
  endtask

  task automatic t_dual_press();
    press(1'b1, 2);
    @(negedge clk);
    btn_one = 1'b1; btn_zero = 1'b1;
    idle(3);
    btn_one = 1'b0; btn_zero = 1'b0;
    idle(5);
    expect_out(1'b0, 1'b0, "R8 dual press gives no result");
    press(1'b0, 2); press(1'b1, 2);
    expect_out(1'b0, 1'b0, "R8 dual press did not advance");
    press(1'b0, 2);
    expect_out(1'b1, 1'b0, "R8 code completes after dual press");
    do_clear();
  endtask

  task automatic t_clear_mid_entry();
    press(1'b0, 2); press(1'b1, 2);
    do_clear();
    press(1'b1, 2); press(1'b0, 2); press(1'b1, 2);
    expect_out(1'b0, 1'b0, "R6 clear restarts position");
    press(1'b0, 2);
    expect_out(1'b1, 1'b0, "R6 fresh entry passes after clear");
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    expect_out(1'b0, 1'b0, "R10 reset clears result");
  endtask

  initial begin
    t_reset();
    t_correct_code();
    t_wrong_first();
    t_wrong_last();
    t_long_hold();
    t_dual_press();
    t_clear_mid_entry();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // R11 exclusivity checked continuously at the ports
  always @(negedge clk) begin
    if (rst === 1'b0 && pass_o === 1'b1 && fail_o === 1'b1) begin
      n_tests++;
      n_fail++;
      $display("FAIL R11: {pass,fail} actual 11 expected not 11");
    end
  end

endmodule